// File: doc/BRIEF.md
# Countdown Timer with Register Interface

This block is a down-counting interval timer with a small word-addressed register interface and one interrupt line. Software writes a reload value and then sets the run bit in the control word. While running, the live count drops by one on every cycle where the tick-enable input is high. When the count sits at zero, the next tick either reloads it from the stored period or leaves it parked at zero. The choice follows a single control bit, which also gates the interrupt.

The interface carries valid, write, a byte offset, an access-size code and a 32-bit data word. Byte 0 travels in bits 31:24, so the most significant byte leads. Read data and the error flag are registered and appear in the cycle after the request. Accesses with a bad size, a bad alignment, an unmapped offset or a write to the read-only count are rejected: they change nothing, a rejected read returns zero, and the error output pulses.

Top module: `cdt_timer`

## Requirements
- R1: After reset the status, control, period and live-count registers read as zero, and irq, bus_err and bus_rdata are low.
- R2: A legal word write to offset 0x0 (status), 0x4 (control) or 0x8 (period) stores the full data word. A legal read returns it on bus_rdata in the cycle after the request.
- R3: The count changes only on a cycle with tick_en high while control bit 2 (run) is set. On such a tick a nonzero count decreases by exactly one.
- R4: On a running tick with the count at zero, the count is loaded from the period register if control bit 0 (auto) is set. If auto is clear, the count stays at zero.
- R5: irq is high for exactly the cycle after a running tick whose updated count is zero while auto is set, and is low at all other times.
- R6: Offset 0xC returns the live count. A write to 0xC is an illegal access and leaves the count unchanged.
- R7: An access is illegal if its size code is not 2'b10 (word), its offset is not a multiple of four, or its offset is 0x10 or above. An illegal access raises bus_err for the following cycle only, changes no register, and, when it is a read, returns zero on bus_rdata.
- R8: A control write on the same cycle as a tick does not affect that tick; the new value governs the next tick. A period write leaves a count in progress untouched and is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count-rate strobe; the timer advances only on cycles where it is high |
| bus_valid | input | 1 | Access request strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte offset of the access |
| bus_size | input | 2 | Access size code: 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data, most significant byte in bits 31:24 |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A corrupted count shows up on the next snapshot read, one cycle after the request. It also shifts the irq pulse away from the tick on which the bench predicts the count reaches zero. If the decode is wrong, a rejected access changes a register: the following read-back exposes it, and bus_err stays low in the cycle after the bad request. A wrong choice of control value at a tick edge moves the count by one tick, which a snapshot read taken just after that edge shows.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // access size codes on bus_size
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } cdt_size_e;

  // register word indices (offset / 4)
  localparam int IDX_STATUS = 0;
  localparam int IDX_CTRL   = 1;
  localparam int IDX_PERIOD = 2;
  localparam int IDX_SNAP   = 3;
  localparam int NUM_REGS   = 4;
  localparam int NUM_RW     = 3;

  // control word bit positions
  localparam int AUTO_BIT = 0;
  localparam int RUN_BIT  = 2;
endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cdt_regfile.sv
module cdt_regfile
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] live_count,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              ctrl_run,
  output logic              ctrl_auto,
  output logic [DATA_W-1:0] period
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  word_idx;
  logic              aligned;
  logic              size_ok;
  logic              in_map;
  logic              rd_legal;
  logic              wr_legal;
  logic              rd_req;
  logic              wr_req;
  logic [DATA_W-1:0] rw_q [NUM_RW];
  logic [DATA_W-1:0] rw_d [NUM_RW];
  logic [DATA_W-1:0] mux_data;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;

  // decode
  always_comb begin
    word_idx = bus_addr[ADDR_W-1:2];
    aligned  = (bus_addr[1:0] == 2'b00);
    size_ok  = (cdt_size_e'(bus_size) == SZ_WORD);
    in_map   = (int'(word_idx) < NUM_REGS);
    rd_legal = size_ok && aligned && in_map;
    wr_legal = rd_legal && (int'(word_idx) != IDX_SNAP);
    rd_req   = bus_valid && !bus_write;
    wr_req   = bus_valid && bus_write;
  end

  // read/write registers, one per mapped index
  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    logic wr_en;
    always_comb begin
      wr_en = wr_req && wr_legal && (int'(word_idx) == g);
      rw_d[g] = wr_en ? bus_wdata : rw_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rw_q[g] <= '0;
      else        rw_q[g] <= rw_d[g];
    end
  end

  // read mux
  always_comb begin
    mux_data = '0;
    case (int'(word_idx))
      IDX_STATUS: mux_data = rw_q[IDX_STATUS];
      IDX_CTRL:   mux_data = rw_q[IDX_CTRL];
      IDX_PERIOD: mux_data = rw_q[IDX_PERIOD];
      IDX_SNAP:   mux_data = live_count;
      default:    mux_data = '0;
    endcase
  end

  // response next state
  always_comb begin
    rdata_d = rdata_q;
    if (rd_req) rdata_d = rd_legal ? mux_data : '0;
    err_d = (rd_req && !rd_legal) || (wr_req && !wr_legal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign ctrl_run  = rw_q[IDX_CTRL][RUN_BIT];
  assign ctrl_auto = rw_q[IDX_CTRL][AUTO_BIT];
  assign period    = rw_q[IDX_PERIOD];
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run,
  input  logic              auto,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] count,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              irq_q, irq_d;
  logic              step;

  always_comb begin
    step  = tick_en && run;
    cnt_d = cnt_q;
    irq_d = 1'b0;
    if (step) begin
      if (cnt_q != '0)  cnt_d = cnt_q - ONE;
      else if (auto)    cnt_d = period;
      // decision uses the value after this tick's update
      irq_d = (cnt_d == '0) && auto;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              irq
);
  logic              rst_sync_n;
  logic              run_w;
  logic              auto_w;
  logic [DATA_W-1:0] period_w;
  logic [DATA_W-1:0] count_w;

  cdt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdt_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .live_count (count_w),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .ctrl_run   (run_w),
    .ctrl_auto  (auto_w),
    .period     (period_w)
  );

  cdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .run     (run_w),
    .auto    (auto_w),
    .period  (period_w),
    .count   (count_w),
    .irq     (irq)
  );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              tick_en,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              irq,
  input logic              run,
  input logic              auto,
  input logic [DATA_W-1:0] period,
  input logic [DATA_W-1:0] count
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick_en && run && count != '0) |=> (count == $past(count) - ONE));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(tick_en && run) |=> $stable(count));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick_en && run && count == '0 && auto) |=> (count == $past(period)));

  p_park_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick_en && run && count == '0 && !auto) |=> (count == '0));

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> ($past(tick_en && run && auto) && count == '0));

  p_irq_fire_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick_en && run && auto && (count == ONE || (count == '0 && period == '0))) |=> irq);

  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_err |-> $past(bus_valid));

  p_err_nochange_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_err |-> ($stable(period) && $stable(run) && $stable(auto)));

  p_err_rdzero_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_err && $past(!bus_write)) |-> (bus_rdata == '0));
endmodule

bind cdt_timer cdt_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tick_en    (tick_en),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .irq        (irq),
  .run        (run_w),
  .auto       (auto_w),
  .period     (period_w),
  .count      (count_w)
);

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_STAT = 6'h00;
  localparam logic [AW-1:0] A_CTRL = 6'h04;
  localparam logic [AW-1:0] A_PER  = 6'h08;
  localparam logic [AW-1:0] A_SNAP = 6'h0C;
  localparam logic [1:0] SZ_W = 2'd2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_en;
  logic          bus_valid;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cdt_timer #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one bus cycle, optionally with a tick on the same edge; results sampled after the edge
  task automatic xfer(input bit wr, input logic [AW-1:0] addr, input logic [1:0] size,
                      input logic [DW-1:0] wd, input bit tk,
                      output logic [DW-1:0] rd, output logic err, output logic irq_o);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_size = size;
    bus_wdata = wd; tick_en = tk;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tick_en = 1'b0;
    rd = bus_rdata; err = bus_err; irq_o = irq;
  endtask

  task automatic wr32(input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    logic [DW-1:0] rd; logic e; logic q;
    xfer(1'b1, addr, SZ_W, wd, 1'b0, rd, e, q);
  endtask

  task automatic rd32(input logic [AW-1:0] addr, output logic [DW-1:0] rd);
    logic e; logic q;
    xfer(1'b0, addr, SZ_W, '0, 1'b0, rd, e, q);
  endtask

  task automatic tick(output logic irq_o);
    @(negedge clk);
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    irq_o = irq;
  endtask

  // drive count to zero, then load it with p; leaves control at run|auto
  task automatic load_count(input logic [DW-1:0] p);
    logic [DW-1:0] s; logic q;
    wr32(A_CTRL, 32'h4);
    rd32(A_SNAP, s);
    for (int i = 0; i < int'(s); i++) tick(q);
    wr32(A_PER, p);
    wr32(A_CTRL, 32'h5);
    tick(q);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 err after reset", {31'b0, bus_err}, 0);
    chk("R1 rdata after reset", bus_rdata, 0);
    rd32(A_STAT, v); chk("R1 status", v, 0);
    rd32(A_CTRL, v); chk("R1 control", v, 0);
    rd32(A_PER, v);  chk("R1 period", v, 0);
    rd32(A_SNAP, v); chk("R1 snapshot", v, 0);
  endtask

  task automatic t_rw;
    logic [DW-1:0] v; logic [DW-1:0] rd; logic e; logic q;
    wr32(A_STAT, 32'hA5C3_0F81);
    wr32(A_CTRL, 32'h1234_5670);
    wr32(A_PER,  32'hDEAD_BEEF);
    rd32(A_STAT, v); chk("R2 status readback", v, 32'hA5C3_0F81);
    rd32(A_CTRL, v); chk("R2 control readback", v, 32'h1234_5670);
    xfer(1'b0, A_PER, SZ_W, '0, 1'b0, rd, e, q);
    chk("R2 period readback", rd, 32'hDEAD_BEEF);
    chk("R2 legal read no err", {31'b0, e}, 0);
    wr32(A_CTRL, 32'h0);
  endtask

  task automatic t_countdown;
    logic [DW-1:0] v; logic q;
    load_count(3);
    rd32(A_SNAP, v); chk("R4 reload from zero", v, 3);
    tick(q); chk("R5 no irq at 2", {31'b0, q}, 0);
    rd32(A_SNAP, v); chk("R3 dec to 2", v, 2);
    repeat (5) @(negedge clk);
    rd32(A_SNAP, v); chk("R3 no tick no change", v, 2);
    tick(q);
    rd32(A_SNAP, v); chk("R3 dec to 1", v, 1);
    tick(q); chk("R5 irq at zero", {31'b0, q}, 1);
    @(negedge clk); chk("R5 irq one cycle", {31'b0, irq}, 0);
    rd32(A_SNAP, v); chk("R3 reached 0", v, 0);
    tick(q); chk("R5 no irq on reload", {31'b0, q}, 0);
    rd32(A_SNAP, v); chk("R4 auto reload", v, 3);
  endtask

  task automatic t_stopped;
    logic [DW-1:0] v; logic q;
    wr32(A_CTRL, 32'h1);
    repeat (3) begin
      tick(q); chk("R5 no irq when stopped", {31'b0, q}, 0);
    end
    rd32(A_SNAP, v); chk("R3 run clear holds", v, 3);
  endtask

  task automatic t_park;
    logic [DW-1:0] v; logic q;
    load_count(2);
    wr32(A_CTRL, 32'h4);
    tick(q);
    tick(q); chk("R5 no irq auto clear", {31'b0, q}, 0);
    tick(q); chk("R5 no irq parked", {31'b0, q}, 0);
    rd32(A_SNAP, v); chk("R4 parks at zero", v, 0);
  endtask

  task automatic t_period_zero;
    logic [DW-1:0] v; logic q;
    wr32(A_PER, 0);
    wr32(A_CTRL, 32'h5);
    tick(q); chk("R5 irq period zero a", {31'b0, q}, 1);
    tick(q); chk("R5 irq period zero b", {31'b0, q}, 1);
    rd32(A_SNAP, v); chk("R4 reload zero", v, 0);
  endtask

  task automatic t_ctrl_timing;
    logic [DW-1:0] v; logic [DW-1:0] rd; logic e; logic q;
    load_count(4);
    xfer(1'b1, A_CTRL, SZ_W, 32'h0, 1'b1, rd, e, q);
    rd32(A_SNAP, v); chk("R8 tick uses old control", v, 3);
    tick(q);
    rd32(A_SNAP, v); chk("R8 new control at next tick", v, 3);
    wr32(A_CTRL, 32'h5);
    xfer(1'b1, A_PER, SZ_W, 32'd9, 1'b1, rd, e, q);
    rd32(A_SNAP, v); chk("R8 period write keeps count", v, 2);
    tick(q); tick(q);
    chk("R5 irq after period write", {31'b0, q}, 1);
    tick(q);
    rd32(A_SNAP, v); chk("R8 new period at reload", v, 9);
    wr32(A_CTRL, 32'h0);
  endtask

  task automatic t_illegal;
    logic [DW-1:0] v; logic [DW-1:0] rd; logic e; logic q;
    logic [DW-1:0] snap;
    wr32(A_PER, 32'h55);
    xfer(1'b1, A_PER, 2'd0, 32'h77, 1'b0, rd, e, q);
    chk("R7 byte write err", {31'b0, e}, 1);
    @(negedge clk); chk("R7 err one cycle", {31'b0, bus_err}, 0);
    rd32(A_PER, v); chk("R7 byte write ignored", v, 32'h55);
    xfer(1'b0, A_PER, 2'd1, '0, 1'b0, rd, e, q);
    chk("R7 half read zero", rd, 0);
    chk("R7 half read err", {31'b0, e}, 1);
    xfer(1'b1, 6'h09, SZ_W, 32'h99, 1'b0, rd, e, q);
    chk("R7 misaligned err", {31'b0, e}, 1);
    rd32(A_PER, v); chk("R7 misaligned ignored", v, 32'h55);
    xfer(1'b0, 6'h10, SZ_W, '0, 1'b0, rd, e, q);
    chk("R7 unmapped read zero", rd, 0);
    chk("R7 unmapped err", {31'b0, e}, 1);
    rd32(A_SNAP, snap);
    xfer(1'b1, A_SNAP, SZ_W, 32'h1234, 1'b0, rd, e, q);
    chk("R6 snapshot write err", {31'b0, e}, 1);
    rd32(A_SNAP, v); chk("R6 snapshot unchanged", v, snap);
    xfer(1'b0, A_SNAP, SZ_W, '0, 1'b0, rd, e, q);
    chk("R6 snapshot read legal", {31'b0, e}, 0);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_size = SZ_W; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_rw();
    t_countdown();
    t_stopped();
    t_park();
    t_period_zero();
    t_ctrl_timing();
    t_illegal();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule